// File: doc/BRIEF.md
# Serial Receive Byte Queue with Level Flag and Idle Timeout

This block holds received serial bytes between the deserializer and the register read path. The deserializer offers bytes, or a line-break indication, on the write side. A read of the data register pops the oldest byte on the read side. The storage is a ring described by a write index and an occupancy count. The read index is not stored; it is derived from those two.

The block reports occupancy, empty, full, and whether occupancy has reached a programmable level. It raises single-cycle pulses in two cases: a byte is lost because the queue is full, or the line has been quiet for four character times after the last stored byte. A receiver enable and a receiver disable input gate both sides. A flush command empties the queue.

Top module: `rxq_fifo`

## Requirements
- R1: After reset, `count` is 0, `empty` is 1, `full` and `level_hit` are 0, `overflow` and `timeout` are 0, and `rd_data` is 0x00.
- R2: Bytes stored by accepted writes are returned by reads in arrival order. The read data appears on `rd_data` in the cycle after the clock edge that sampled `rd_req`, and it holds until the next read.
- R3: A read while receive is active and the queue is empty returns 0x00 on `rd_data` and leaves `count` at 0.
- R4: `count` gives the number of stored bytes (0 to DEPTH). `empty` is 1 exactly when `count` is 0, and `full` is 1 exactly when `count` equals DEPTH.
- R5: A write attempt while receive is active and the queue is full stores nothing. It leaves `count` at DEPTH and raises `overflow` for exactly one cycle, in the cycle after the attempt.
- R6: Receive is active only when `rx_en` is 1 and `rx_dis` is 0. While it is not active, writes store nothing, reads pop nothing and return 0x00, and `count` does not change.
- R7: A write with `wr_break` set stores the byte 0x00, whatever `wr_data` holds.
- R8: `flush` empties the queue: in the next cycle `count` is 0 and `empty` is 1. A write or read in the same cycle as `flush` is discarded.
- R9: Each stored byte restarts an idle timer of 4 × `char_cycles` clock cycles. If the byte is stored at edge E, `timeout` is 1 for one cycle right after edge E + 4·`char_cycles`, and 0 otherwise.
- R10: A byte stored while the timer is running restarts the full interval from that byte. After it fires, the timer stays idle until the next stored byte.
- R11: `flush` stops a running idle timer, so no `timeout` follows until a new byte is stored.
- R12: `level_hit` is 1 exactly when `count` is greater than or equal to `trig_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| rx_dis | input | 1 | Receiver disable (overrides enable) |
| flush | input | 1 | Empty the queue and stop the idle timer |
| wr_valid | input | 1 | Deserializer offers `wr_data` |
| wr_data | input | 8 | Received byte |
| wr_break | input | 1 | Line break received; stores 0x00 |
| rd_req | input | 1 | Data register read (pop) |
| char_cycles | input | CHAR_W (16) | One character time in clock cycles |
| trig_level | input | CW (7) | Occupancy level for `level_hit` |
| rd_data | output | 8 | Popped byte, or 0x00 |
| count | output | CW (7) | Stored byte count |
| empty | output | 1 | Queue empty |
| full | output | 1 | Queue full |
| level_hit | output | 1 | Count at or above `trig_level` |
| overflow | output | 1 | One-cycle pulse: byte lost while full |
| timeout | output | 1 | One-cycle pulse: line idle for four character times |

## Verification
The ordering check uses a short burst on an empty queue, then a full fill, a rejected extra byte, and a complete drain after earlier traffic has moved the write index. The drain makes the derived read index wrap, and that separates a correct ring from one that miscomputes the read position. Reads on an empty queue, and traffic with the receiver gated in either way, separate a pop that returns zero from one that returns stale memory or corrupts the count. Timer runs with one byte, with a byte arriving mid-interval, and with a flush mid-interval separate a restarting timer from a free-running or one-shot-from-first-byte timer.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef logic [7:0] rxq_byte_t;

  // per-cycle queue operation decided by the controller
  typedef struct packed {
    logic push;
    logic pop;
    logic drop;
  } rxq_op_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  rxq_pkg::rxq_byte_t   wdata,
  input  logic                 re,
  input  logic [AW-1:0]        raddr,
  output rxq_pkg::rxq_byte_t   rdata
);
  rxq_pkg::rxq_byte_t mem [DEPTH];

  // simple dual-port memory with a registered read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int CW    = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             active,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic [CW-1:0]    trig_level,
  output logic [AW-1:0]    wptr,
  output logic [AW-1:0]    rptr,
  output rxq_pkg::rxq_op_t op,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full,
  output logic             level_hit,
  output logic             overflow,
  output logic             rd_zero
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam bit            POW2     = (DEPTH == (1 << AW));

  logic [CW-1:0] cnt_next;
  logic          at_full;
  logic          at_empty;

  assign at_full  = (count == FULL_CNT);
  assign at_empty = (count == '0);

  always_comb begin
    op.push = push_req && active && !flush && !at_full;
    op.drop = push_req && active && !flush &&  at_full;
    op.pop  = pop_req  && active && !flush && !at_empty;
  end

  // read index derived from write index and occupancy
  generate
    if (POW2) begin : g_rd_pow2
      assign rptr = wptr - AW'(count);
    end else begin : g_rd_mod
      logic [CW:0] wsum;
      assign wsum = (CW+1)'(wptr) + (CW+1)'(DEPTH) - (CW+1)'(count);
      assign rptr = (wsum >= (CW+1)'(DEPTH)) ? AW'(wsum - (CW+1)'(DEPTH)) : AW'(wsum);
    end
  endgenerate

  always_comb begin
    if (flush) cnt_next = '0;
    else       cnt_next = count + CW'(op.push) - CW'(op.pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      count     <= '0;
      empty     <= 1'b1;
      full      <= 1'b0;
      level_hit <= 1'b0;
      overflow  <= 1'b0;
      rd_zero   <= 1'b1;
    end else begin
      if (flush)        wptr <= '0;
      else if (op.push) wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
      count     <= cnt_next;
      empty     <= (cnt_next == '0);
      full      <= (cnt_next == FULL_CNT);
      level_hit <= (cnt_next >= trig_level);
      overflow  <= op.drop;
      if (pop_req) rd_zero <= !op.pop;
    end
  end
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int CHAR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              start,
  input  logic [CHAR_W-1:0] char_cycles,
  output logic              timeout
);
  localparam int TW = CHAR_W + 2;

  logic [TW-1:0] remain;
  logic          running;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain  <= '0;
      running <= 1'b0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (flush) begin
        running <= 1'b0;
      end else if (start) begin
        remain  <= {char_cycles, 2'b00};
        running <= 1'b1;
      end else if (running) begin
        if (remain <= TW'(1)) begin
          running <= 1'b0;
          timeout <= 1'b1;
        end else begin
          remain <= remain - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH  = 64,
  parameter int CHAR_W = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              rx_dis,
  input  logic              flush,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  input  logic              wr_break,
  input  logic              rd_req,
  input  logic [CHAR_W-1:0] char_cycles,
  input  logic [CW-1:0]     trig_level,
  output logic [7:0]        rd_data,
  output logic [CW-1:0]     count,
  output logic              empty,
  output logic              full,
  output logic              level_hit,
  output logic              overflow,
  output logic              timeout
);
  logic               active;
  logic [AW-1:0]      wptr;
  logic [AW-1:0]      rptr;
  rxq_pkg::rxq_op_t   op;
  rxq_pkg::rxq_byte_t in_byte;
  rxq_pkg::rxq_byte_t mem_q;
  logic               rd_zero;

  assign active  = rx_en && !rx_dis;
  assign in_byte = wr_break ? 8'h00 : wr_data;

  rxq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .active(active),
    .push_req(wr_valid || wr_break), .pop_req(rd_req),
    .trig_level(trig_level), .wptr(wptr), .rptr(rptr), .op(op),
    .count(count), .empty(empty), .full(full), .level_hit(level_hit),
    .overflow(overflow), .rd_zero(rd_zero)
  );

  rxq_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(op.push), .waddr(wptr), .wdata(in_byte),
    .re(op.pop), .raddr(rptr), .rdata(mem_q)
  );

  rxq_idle_timer #(.CHAR_W(CHAR_W)) u_timer (
    .clk(clk), .rst(rst), .flush(flush), .start(op.push),
    .char_cycles(char_cycles), .timeout(timeout)
  );

  assign rd_data = rd_zero ? 8'h00 : mem_q;
endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_en,
  input logic          rx_dis,
  input logic          flush,
  input logic          rd_req,
  input logic [7:0]    rd_data,
  input logic [CW-1:0] count,
  input logic          empty,
  input logic          full,
  input logic          overflow,
  input logic          timeout
);
  logic on;
  assign on = rx_en && !rx_dis;

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  assert_overflow_after_full_R5: assert property (@(posedge clk) disable iff (rst)
    overflow |-> $past(full));

  assert_gated_count_still_R6: assert property (@(posedge clk) disable iff (rst)
    (!on && !flush) |=> $stable(count));

  assert_empty_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_req && on && empty && !flush) |=> (rd_data == 8'h00 && count == '0));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0 && empty));

  assert_timeout_single_R9: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout);
endmodule

bind rxq_fifo rxq_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_rxq_fifo_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .rx_dis(rx_dis), .flush(flush),
  .rd_req(rd_req), .rd_data(rd_data), .count(count), .empty(empty),
  .full(full), .overflow(overflow), .timeout(timeout)
);

// File: tb/rxq_fifo_bench.sv
module rxq_fifo_bench;
  localparam int DEPTH = 64;
  localparam int CW    = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_en = 1'b0, rx_dis = 1'b0, flush = 1'b0;
  logic        wr_valid = 1'b0, wr_break = 1'b0, rd_req = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [15:0] char_cycles = 16'd3;
  logic [CW-1:0] trig_level = 7'd32;
  logic [7:0]  rd_data;
  logic [CW-1:0] count;
  logic        empty, full, level_hit, overflow, timeout;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [7:0] model_q[$];
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  rxq_fifo u_rxq_fifo (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_dis(rx_dis), .flush(flush),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_break(wr_break),
    .rd_req(rd_req), .char_cycles(char_cycles), .trig_level(trig_level),
    .rd_data(rd_data), .count(count), .empty(empty), .full(full),
    .level_hit(level_hit), .overflow(overflow), .timeout(timeout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit on();
    return rx_en && !rx_dis;
  endfunction

  task automatic wr(input logic [7:0] d, input bit brk);
    @(negedge clk);
    wr_valid = !brk; wr_break = brk; wr_data = d;
    if (on() && model_q.size() < DEPTH) model_q.push_back(brk ? 8'h00 : d);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; wr_break = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk);
    rd_req = 1'b1;
    if (on() && model_q.size() > 0) exp_q.push_back(model_q.pop_front());
    else exp_q.push_back(8'h00);
    @(posedge clk);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    model_q.delete();
    @(posedge clk);
    @(negedge clk);
    flush = 1'b0;
  endtask

  // scoreboard monitor: compares popped data against driver expectations (R2)
  always @(posedge clk) begin
    if (rd_req) begin
      #1;
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected read", 0, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R2 read data", int'(rd_data), int'(e));
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(count == 0 && empty && !full && !level_hit, "R1 flags", int'(count), 0);
    chk(!overflow && !timeout && rd_data == 8'h00, "R1 pulses/data", int'(rd_data), 0);

    rx_en = 1'b1;
    // R2 short burst
    wr(8'h11, 0); wr(8'h22, 0); wr(8'h33, 0);
    chk(count == 3 && !empty, "R4 count after 3", int'(count), 3);
    rd(); rd(); rd();
    chk(count == 0 && empty, "R4 empty after drain", int'(count), 0);

    // R3 empty read
    rd();
    chk(count == 0 && empty, "R3 empty read count", int'(count), 0);
    chk(rd_data == 8'h00, "R3 empty read data", int'(rd_data), 0);

    // R7 break stores zero
    wr(8'hC7, 1);
    rd();
    chk(count == 0, "R7 count", int'(count), 0);

    // R6 gated by enable / disable
    wr(8'h44, 0);
    rx_en = 1'b0;
    wr(8'h55, 0);
    chk(count == 1, "R6 write while not enabled", int'(count), 1);
    rd();
    chk(count == 1 && rd_data == 8'h00, "R6 read while not enabled", int'(count), 1);
    rx_en = 1'b1; rx_dis = 1'b1;
    wr(8'h66, 0);
    rd();
    chk(count == 1 && rd_data == 8'h00, "R6 disable overrides enable", int'(count), 1);
    rx_dis = 1'b0;
    rd();
    chk(count == 0, "R6 stored byte survives gating", int'(count), 0);

    // R4/R5 fill (write index is mid-ring), overflow, full drain with wrap
    for (int i = 0; i < DEPTH; i++) wr(8'(i) ^ 8'hA5, 0);
    chk(count == 7'(DEPTH) && full && !empty, "R4 full", int'(count), DEPTH);
    wr(8'hEE, 0);
    chk(overflow == 1'b1, "R5 overflow pulse", int'(overflow), 1);
    chk(count == 7'(DEPTH), "R5 count held", int'(count), DEPTH);
    @(negedge clk);
    chk(overflow == 1'b0, "R5 pulse one cycle", int'(overflow), 0);
    for (int i = 0; i < DEPTH; i++) rd();
    chk(count == 0 && empty && !full, "R4 drained", int'(count), 0);

    // R8 flush
    wr(8'h01, 0); wr(8'h02, 0);
    do_flush();
    chk(count == 0 && empty, "R8 flush clears", int'(count), 0);
    wr(8'h77, 0);
    rd();
    chk(count == 0, "R8 usable after flush", int'(count), 0);

    // R12 level flag
    trig_level = 7'd4;
    wr(8'h10, 0); wr(8'h20, 0); wr(8'h30, 0);
    chk(level_hit == 1'b0, "R12 below level", int'(level_hit), 0);
    wr(8'h40, 0);
    chk(level_hit == 1'b1, "R12 at level", int'(level_hit), 1);
    do_flush();
    trig_level = 7'd32;

    // R9 single timeout, 4*3 = 12 cycles after the storing edge
    repeat (20) @(negedge clk);
    wr(8'h5A, 0);
    for (int k = 1; k <= 13; k++) begin
      @(posedge clk); #1;
      chk(timeout == (k == 12), "R9 timeout timing", int'(timeout), int'(k == 12));
    end

    // R10 restart by a second byte
    repeat (20) @(negedge clk);
    wr(8'h5B, 0);
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk); #1;
      chk(timeout == 1'b0, "R10 no early timeout", int'(timeout), 0);
    end
    wr(8'h5C, 0);
    for (int k = 1; k <= 20; k++) begin
      @(posedge clk); #1;
      chk(timeout == (k == 12), "R10 restarted interval", int'(timeout), int'(k == 12));
    end

    // R11 flush cancels timer
    wr(8'h5D, 0);
    do_flush();
    for (int k = 1; k <= 20; k++) begin
      @(posedge clk); #1;
      chk(timeout == 1'b0, "R11 no timeout after flush", int'(timeout), 0);
    end

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all reads compared", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule